// File: doc/BRIEF.md
# Time-Calendar Update Engine

This block holds a wall-clock time and calendar (seconds, minutes, hours, day of week, day of month, month and two-digit year) and moves it forward by one second each time the divider chain delivers a one-second tick. The stored bytes are kept in binary or in packed BCD, chosen by a format input. Hours are held either as 0 to 23 or as a 1 to 12 value with a PM flag in bit 7. An optional daylight-saving rule moves the clock forward one hour on a spring Sunday and back one hour on an autumn Sunday.

Software loads the fields through a byte-wide write port, normally while the hold input is high so that no advance lands halfway through a load. Each completed advance raises a one-cycle done pulse, which the interrupt logic can use. The bus interface, interrupt logic and oscillator are outside this block.

Top module: `tcal_update_engine`

## Requirements
- R1: While rst_n is low the fields reset to seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, monthday 0x01, month 0x01, year 0x00, and upd_done is 0.
- R2: A tick sampled at a rising clock edge with set_hold and wr_en both low advances the time by one second at that edge. The carry goes from seconds (0..59) to minutes (0..59) to hours.
- R3: With bin_mode=1 every field is stored as a plain binary value. With bin_mode=0 every field is two BCD digits, tens in bits 7:4 and units in bits 3:0 (for example 0x09 then 0x10, and 0x59 then 0x00). Every advance writes results back in the format currently selected.
- R4: With h24_mode=1 hours count 0..23, and 23:59:59 rolls over to 00:00:00 and advances the date.
- R5: With h24_mode=0 the hours byte holds 1..12 in bits 6:0, with bit 7 set for PM. In binary this gives 0x01-0x0C and 0x81-0x8C; in BCD it gives 0x01-0x12 and 0x81-0x92. The sequence is 11 AM, 12 PM, 1 PM, and 11 PM rolls over to 12 AM, which advances the date.
- R6: Months 4, 6, 9 and 11 have 30 days. Month 2 has 29 days when the year is a multiple of 4 and 28 days otherwise. All other months have 31 days. After month 12 the month returns to 1 and the year increments, and year 99 wraps to 0.
- R7: The weekday counts 1..7, with 1 meaning Sunday. It steps on every date advance and wraps from 7 to 1.
- R8: While set_hold=1, ticks change no field and raise no upd_done.
- R9: When wr_en=1, wr_data is written into the field chosen by wr_sel (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 monthday, 5 month, 6 year; 7 writes nothing). A tick in that same cycle is dropped: no advance and no upd_done.
- R10: upd_done is high for exactly the one cycle that follows each accepted tick. That is the first cycle in which the advanced values are visible.
- R11: With dst_en=1, on a Sunday with monthday 1..7 in month 4, the advance from 1:59:59 AM goes to 3:00:00 AM.
- R12: With dst_en=1, on a Sunday with monthday 25..31 in month 10, the first advance from 1:59:59 AM goes to 1:00:00 AM. Later passes through 1:59:59 that same day advance normally. The one-shot is re-armed by a date advance or by any write.
- R13: With dst_en=0, neither daylight-saving jump happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-second advance request, one cycle wide |
| set_hold | input | 1 | Blocks advances while high |
| bin_mode | input | 1 | 1 binary, 0 BCD |
| h24_mode | input | 1 | 1 24-hour, 0 12-hour with PM in bit 7 |
| dst_en | input | 1 | Enables the daylight-saving jumps |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selector for writes |
| wr_data | input | 8 | Byte to write |
| seconds | output | 8 | Seconds field |
| minutes | output | 8 | Minutes field |
| hours | output | 8 | Hours field |
| weekday | output | 8 | Day of week field |
| monthday | output | 8 | Day of month field |
| month | output | 8 | Month field |
| year | output | 8 | Year field |
| upd_done | output | 1 | One-cycle pulse after each advance |

## Verification
Every field sits directly on a port, so a wrong carry or a mis-encoded digit shows up on the edge of the faulty advance. That makes it visible at the sample taken one cycle after the tick. A wrong month length or leap rule only shows up at a month boundary, so the stimulus loads times one second before those boundaries. A stuck fall-back one-shot stays hidden until the second pass through 1:59:59 AM, which comes an hour of ticks after the first. The bench therefore runs that whole hour.

// File: rtl/tcal_pkg.sv
package tcal_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 7;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_WDAY = 3;
  localparam int F_MDAY = 4;
  localparam int F_MON  = 5;
  localparam int F_YR   = 6;

  typedef logic [BYTE_W-1:0] tbyte_t;
  typedef tbyte_t [NUM_FIELDS-1:0] tfields_t;

  localparam tbyte_t SEC_LAST  = 8'd59;
  localparam tbyte_t MIN_LAST  = 8'd59;
  localparam tbyte_t HR_LAST   = 8'd23;
  localparam tbyte_t WDAY_LAST = 8'd7;
  localparam tbyte_t MON_LAST  = 8'd12;
  localparam tbyte_t HALF_DAY  = 8'd12;

  // Stored byte to binary value.
  function automatic tbyte_t dec_byte(input tbyte_t v, input logic bin);
    tbyte_t tens;
    tbyte_t units;
    tens  = {4'd0, v[7:4]};
    units = {4'd0, v[3:0]};
    return bin ? v : (tens * 8'd10 + units);
  endfunction

  // Binary value to stored byte.
  function automatic tbyte_t enc_byte(input tbyte_t v, input logic bin);
    tbyte_t q;
    tbyte_t r;
    q = v / 8'd10;
    r = v % 8'd10;
    return bin ? v : {q[3:0], r[3:0]};
  endfunction

  // Stored hours byte to 0..23.
  function automatic tbyte_t hr_to24(input tbyte_t h, input logic h24, input logic bin);
    tbyte_t h12;
    if (h24) return dec_byte(h, bin);
    h12 = dec_byte({1'b0, h[6:0]}, bin);
    if (h12 == HALF_DAY) return h[7] ? HALF_DAY : 8'd0;
    return h[7] ? h12 + HALF_DAY : h12;
  endfunction

  // 0..23 to stored hours byte.
  function automatic tbyte_t hr_from24(input tbyte_t h, input logic h24, input logic bin);
    logic   pm;
    tbyte_t t;
    tbyte_t e;
    if (h24) return enc_byte(h, bin);
    pm = (h >= HALF_DAY);
    t  = pm ? h - HALF_DAY : h;
    if (t == 8'd0) t = HALF_DAY;
    e = enc_byte(t, bin);
    return {pm, e[6:0]};
  endfunction

  function automatic tbyte_t month_len(input tbyte_t mon, input tbyte_t yr, input int leap);
    case (mon)
      8'd2:                     return ((32'(yr) % leap) == 0) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
      default:                  return 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/tcal_decode.sv
module tcal_decode
  import tcal_pkg::*;
(
  input  tfields_t raw,
  input  logic     bin_mode,
  input  logic     h24_mode,
  output tfields_t val
);
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    if (i == F_HR) begin : g_hr
      assign val[i] = hr_to24(raw[i], h24_mode, bin_mode);
    end else begin : g_plain
      assign val[i] = dec_byte(raw[i], bin_mode);
    end
  end
endmodule

// File: rtl/tcal_encode.sv
module tcal_encode
  import tcal_pkg::*;
(
  input  tfields_t val,
  input  logic     bin_mode,
  input  logic     h24_mode,
  output tfields_t raw
);
  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    if (i == F_HR) begin : g_hr
      assign raw[i] = hr_from24(val[i], h24_mode, bin_mode);
    end else begin : g_plain
      assign raw[i] = enc_byte(val[i], bin_mode);
    end
  end
endmodule

// File: rtl/tcal_dst_rules.sv
module tcal_dst_rules
  import tcal_pkg::*;
#(
  parameter int SPRING_MON    = 4,
  parameter int FALL_MON      = 10,
  parameter int WEEK_LEN      = 7,
  parameter int FALL_MON_DAYS = 31,
  parameter int SUNDAY        = 1,
  parameter int EDGE_HOUR     = 1
) (
  input  tbyte_t sec,
  input  tbyte_t min,
  input  tbyte_t hr24,
  input  tbyte_t wday,
  input  tbyte_t mday,
  input  tbyte_t mon,
  input  logic   dst_en,
  output logic   spring_hit,
  output logic   fall_hit
);
  localparam tbyte_t FIRST_WEEK_END  = tbyte_t'(WEEK_LEN);
  localparam tbyte_t LAST_WEEK_AFTER = tbyte_t'(FALL_MON_DAYS - WEEK_LEN);

  logic at_edge;
  logic is_sunday;

  assign at_edge   = (sec == SEC_LAST) && (min == MIN_LAST) && (hr24 == tbyte_t'(EDGE_HOUR));
  assign is_sunday = (wday == tbyte_t'(SUNDAY));

  assign spring_hit = dst_en && at_edge && is_sunday &&
                      (mon == tbyte_t'(SPRING_MON)) && (mday <= FIRST_WEEK_END);
  assign fall_hit   = dst_en && at_edge && is_sunday &&
                      (mon == tbyte_t'(FALL_MON)) && (mday > LAST_WEEK_AFTER);
endmodule

// File: rtl/tcal_step.sv
module tcal_step
  import tcal_pkg::*;
#(
  parameter int LEAP_PERIOD = 4,
  parameter int YEAR_WRAP   = 100,
  parameter int SPRING_HOUR = 3,
  parameter int FALL_HOUR   = 1
) (
  input  tfields_t now,
  input  logic     spring_hit,
  input  logic     fall_apply,
  output tfields_t nxt,
  output logic     day_adv
);
  localparam tbyte_t YEAR_LAST = tbyte_t'(YEAR_WRAP - 1);

  tbyte_t mlen;
  assign mlen = month_len(now[F_MON], now[F_YR], LEAP_PERIOD);

  always_comb begin
    nxt     = now;
    day_adv = 1'b0;
    if (spring_hit) begin
      nxt[F_SEC] = 8'd0;
      nxt[F_MIN] = 8'd0;
      nxt[F_HR]  = tbyte_t'(SPRING_HOUR);
    end else if (fall_apply) begin
      nxt[F_SEC] = 8'd0;
      nxt[F_MIN] = 8'd0;
      nxt[F_HR]  = tbyte_t'(FALL_HOUR);
    end else if (now[F_SEC] < SEC_LAST) begin
      nxt[F_SEC] = now[F_SEC] + 8'd1;
    end else begin
      nxt[F_SEC] = 8'd0;
      if (now[F_MIN] < MIN_LAST) begin
        nxt[F_MIN] = now[F_MIN] + 8'd1;
      end else begin
        nxt[F_MIN] = 8'd0;
        if (now[F_HR] < HR_LAST) begin
          nxt[F_HR] = now[F_HR] + 8'd1;
        end else begin
          nxt[F_HR]   = 8'd0;
          day_adv     = 1'b1;
          nxt[F_WDAY] = (now[F_WDAY] >= WDAY_LAST) ? 8'd1 : now[F_WDAY] + 8'd1;
          if (now[F_MDAY] < mlen) begin
            nxt[F_MDAY] = now[F_MDAY] + 8'd1;
          end else begin
            nxt[F_MDAY] = 8'd1;
            if (now[F_MON] < MON_LAST) begin
              nxt[F_MON] = now[F_MON] + 8'd1;
            end else begin
              nxt[F_MON] = 8'd1;
              nxt[F_YR]  = (now[F_YR] >= YEAR_LAST) ? 8'd0 : now[F_YR] + 8'd1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/tcal_update_engine.sv
module tcal_update_engine
  import tcal_pkg::*;
#(
  parameter int LEAP_PERIOD = 4,
  parameter int YEAR_WRAP   = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic       set_hold,
  input  logic       bin_mode,
  input  logic       h24_mode,
  input  logic       dst_en,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] seconds,
  output logic [7:0] minutes,
  output logic [7:0] hours,
  output logic [7:0] weekday,
  output logic [7:0] monthday,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic       upd_done
);
  tfields_t cur_q;
  tfields_t cur_bin;
  tfields_t nxt_bin;
  tfields_t nxt_raw;
  logic     fb_done;
  logic     spring_hit;
  logic     fall_hit;
  logic     fall_apply;
  logic     day_adv;
  logic     advance;

  assign advance    = sec_tick && !set_hold && !wr_en;
  assign fall_apply = fall_hit && !fb_done;

  tcal_decode u_dec (
    .raw(cur_q), .bin_mode(bin_mode), .h24_mode(h24_mode), .val(cur_bin)
  );

  tcal_dst_rules u_dst (
    .sec(cur_bin[F_SEC]), .min(cur_bin[F_MIN]), .hr24(cur_bin[F_HR]),
    .wday(cur_bin[F_WDAY]), .mday(cur_bin[F_MDAY]), .mon(cur_bin[F_MON]),
    .dst_en(dst_en), .spring_hit(spring_hit), .fall_hit(fall_hit)
  );

  tcal_step #(.LEAP_PERIOD(LEAP_PERIOD), .YEAR_WRAP(YEAR_WRAP)) u_step (
    .now(cur_bin), .spring_hit(spring_hit), .fall_apply(fall_apply),
    .nxt(nxt_bin), .day_adv(day_adv)
  );

  tcal_encode u_enc (
    .val(nxt_bin), .bin_mode(bin_mode), .h24_mode(h24_mode), .raw(nxt_raw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q         <= '0;
      cur_q[F_WDAY] <= 8'd1;
      cur_q[F_MDAY] <= 8'd1;
      cur_q[F_MON]  <= 8'd1;
      fb_done       <= 1'b0;
      upd_done      <= 1'b0;
    end else begin
      upd_done <= advance;
      if (wr_en) begin
        for (int i = 0; i < NUM_FIELDS; i++) begin
          if (wr_sel == 3'(i)) cur_q[i] <= wr_data;
        end
        fb_done <= 1'b0;
      end else if (advance) begin
        cur_q <= nxt_raw;
        if (fall_apply)   fb_done <= 1'b1;
        else if (day_adv) fb_done <= 1'b0;
      end
    end
  end

  assign seconds  = cur_q[F_SEC];
  assign minutes  = cur_q[F_MIN];
  assign hours    = cur_q[F_HR];
  assign weekday  = cur_q[F_WDAY];
  assign monthday = cur_q[F_MDAY];
  assign month    = cur_q[F_MON];
  assign year     = cur_q[F_YR];

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hold && !wr_en) |=> $stable({seconds, minutes, hours, weekday, monthday, month, year}));

  // R10
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> $past(sec_tick && !set_hold && !wr_en));

  // R9
  sec_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seconds) |-> $past(sec_tick || wr_en));

  // R12
  fb_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_done) |-> $past(fall_apply && advance));

  // R12
  fb_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_done && !wr_en && !(advance && day_adv)) |=> fb_done);
endmodule

// File: tb/test_tcal_update_engine.sv
module test_tcal_update_engine;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0, set_hold = 1'b0, bin_mode = 1'b0, h24_mode = 1'b1;
  logic       dst_en = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] seconds, minutes, hours, weekday, monthday, month, year;
  logic       upd_done;

  int n_chk = 0;
  int n_err = 0;
  int ms, mm, mh, mw, md, mo, my;
  bit mfb;

  always #5 clk = ~clk;

  tcal_update_engine i_tcal_update_engine (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .set_hold(set_hold),
    .bin_mode(bin_mode), .h24_mode(h24_mode), .dst_en(dst_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .seconds(seconds), .minutes(minutes),
    .hours(hours), .weekday(weekday), .monthday(monthday), .month(month),
    .year(year), .upd_done(upd_done)
  );

  function automatic int days_of(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] enc(int v);
    if (bin_mode) return 8'(v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] enc_hr(int h);
    int t;
    if (h24_mode) return enc(h);
    t = h % 12;
    if (t == 0) t = 12;
    return enc(t) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic void model_step();
    bit edge1 = (ms == 59 && mm == 59 && mh == 1 && mw == 1);
    if (dst_en && edge1 && mo == 4 && md <= 7) begin
      mh = 3; mm = 0; ms = 0;
    end else if (dst_en && edge1 && mo == 10 && md >= 25 && !mfb) begin
      mh = 1; mm = 0; ms = 0; mfb = 1;
    end else begin
      ms++;
      if (ms == 60) begin ms = 0; mm++; end
      if (mm == 60) begin mm = 0; mh++; end
      if (mh == 24) begin
        mh = 0; mfb = 0;
        mw = (mw == 7) ? 1 : mw + 1;
        md++;
        if (md > days_of(mo, my)) begin md = 1; mo++; end
        if (mo == 13) begin mo = 1; my = (my + 1) % 100; end
      end
    end
  endfunction

  task automatic check_val(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check_val(tag, {8'h0, seconds, minutes, hours, weekday, monthday, month, year},
              {8'h0, enc(ms), enc(mm), enc_hr(mh), enc(mw), enc(md), enc(mo), enc(my)});
  endtask

  task automatic load(input bit b, input bit h24, input bit dst,
                      input int s, input int m, input int h, input int w,
                      input int d, input int mon, input int y);
    logic [7:0] vals [7];
    @(negedge clk);
    bin_mode = b; h24_mode = h24; dst_en = dst;
    ms = s; mm = m; mh = h; mw = w; md = d; mo = mon; my = y; mfb = 0;
    vals[0] = enc(s); vals[1] = enc(m); vals[2] = enc_hr(h); vals[3] = enc(w);
    vals[4] = enc(d); vals[5] = enc(mon); vals[6] = enc(y);
    set_hold = 1'b1;
    wr_en = 1'b1;
    for (int i = 0; i < 7; i++) begin
      wr_sel = 3'(i); wr_data = vals[i];
      @(negedge clk);
    end
    wr_en = 1'b0;
    set_hold = 1'b0;
  endtask

  task automatic tick(input string tag, input bit chk_low);
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    model_step();
    check_all(tag);
    check_val({tag, " pulse"}, 64'(upd_done), 64'd1);
    if (chk_low) begin
      @(negedge clk);
      check_val({tag, " pulse end"}, 64'(upd_done), 64'd0);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int pick;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    check_val("R1 fields", {8'h0, seconds, minutes, hours, weekday, monthday, month, year},
              64'h00_00_00_00_01_01_01_00);
    check_val("R1 upd_done", 64'(upd_done), 64'd0);
    rst_n = 1'b1;

    // R3: BCD digit carry and binary counting
    load(0, 1, 0, 9, 0, 0, 3, 10, 5, 20);
    tick("R3 bcd units", 1);
    check_val("R3 bcd 0x10", 64'(seconds), 64'h10);
    load(1, 1, 0, 9, 0, 0, 3, 10, 5, 20);
    tick("R3 binary", 0);
    check_val("R3 bin 0x0A", 64'(seconds), 64'h0A);
    // R2: carry into hours
    load(0, 1, 0, 59, 59, 0, 3, 10, 5, 20);
    tick("R2 carry", 0);
    check_val("R2 hour 01", 64'(hours), 64'h01);

    // R4 / R6: end of century in 24-hour BCD
    load(0, 1, 0, 59, 59, 23, 4, 31, 12, 99);
    tick("R4 R6 new year", 0);
    check_val("R6 year wrap", {40'h0, monthday, month, year}, 64'h01_01_00);

    // R5: 12-hour transitions
    load(0, 0, 0, 59, 59, 11, 2, 5, 6, 21);
    tick("R5 noon", 0);
    check_val("R5 12PM bcd", 64'(hours), 64'h92);
    tick("R5 noon next", 0);
    load(0, 0, 0, 59, 59, 12, 2, 5, 6, 21);
    tick("R5 1PM", 0);
    check_val("R5 1PM bcd", 64'(hours), 64'h81);
    load(0, 0, 0, 59, 59, 23, 2, 5, 6, 21);
    tick("R5 midnight", 0);
    check_val("R5 12AM date", {48'h0, hours, monthday}, 64'h12_06);
    load(1, 0, 0, 59, 59, 11, 2, 5, 6, 21);
    tick("R5 bin noon", 0);
    check_val("R5 12PM bin", 64'(hours), 64'h8C);

    // R6: month lengths and leap years
    load(1, 1, 0, 59, 59, 23, 5, 28, 2, 24);
    tick("R6 leap", 0);
    check_val("R6 feb29", {48'h0, monthday, month}, 64'h1D_02);
    load(1, 1, 0, 59, 59, 23, 5, 28, 2, 23);
    tick("R6 common", 0);
    check_val("R6 mar1", {48'h0, monthday, month}, 64'h01_03);
    load(0, 1, 0, 59, 59, 23, 5, 30, 4, 23);
    tick("R6 30day", 0);

    // R7: weekday wrap
    load(0, 1, 0, 59, 59, 23, 7, 14, 8, 30);
    tick("R7 wrap", 0);
    check_val("R7 sunday", 64'(weekday), 64'h01);

    // R8: hold blocks ticks
    load(0, 1, 0, 59, 59, 23, 7, 14, 8, 30);
    @(negedge clk); set_hold = 1'b1; sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
    check_all("R8 frozen");
    check_val("R8 no pulse", 64'(upd_done), 64'd0);
    set_hold = 1'b0;

    // R9: write beats a tick in the same cycle
    @(negedge clk); sec_tick = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = enc(7);
    @(negedge clk); sec_tick = 1'b0; wr_en = 1'b0;
    mm = 7;
    check_all("R9 collision");
    check_val("R9 no pulse", 64'(upd_done), 64'd0);
    @(negedge clk); wr_en = 1'b1; wr_sel = 3'd7; wr_data = 8'h33;
    @(negedge clk); wr_en = 1'b0;
    check_all("R9 sel7 ignored");

    // R11 / R13: spring forward
    load(1, 0, 1, 59, 59, 1, 1, 6, 4, 25);
    tick("R11 spring", 0);
    check_val("R11 3AM", {40'h0, hours, minutes, seconds}, 64'h03_00_00);
    load(1, 0, 0, 59, 59, 1, 1, 6, 4, 25);
    tick("R13 dst off", 0);
    check_val("R13 2AM", 64'(hours), 64'h02);

    // R12: fall back once, then normal
    load(0, 1, 1, 58, 59, 1, 1, 28, 10, 29);
    tick("R12 pre", 0);
    tick("R12 fall", 0);
    check_val("R12 1AM", {40'h0, hours, minutes, seconds}, 64'h01_00_00);
    for (int k = 0; k < 3599; k++) tick("R12 hour", 0);
    tick("R12 second pass", 0);
    check_val("R12 2AM", 64'(hours), 64'h02);

    // R2..R7: randomized near-boundary times
    for (int it = 0; it < 250; it++) begin
      int s, m, h, w, d, mon, y;
      mon = 1 + $urandom % 12;
      y   = ($urandom % 4 == 0) ? 99 : $urandom % 100;
      s   = ($urandom % 2) ? 59 : $urandom % 60;
      m   = ($urandom % 2) ? 59 : $urandom % 60;
      pick = $urandom % 6;
      h   = (pick == 0) ? 23 : (pick == 1) ? 11 : (pick == 2) ? 0 :
            (pick == 3) ? 12 : $urandom % 24;
      w   = 1 + $urandom % 7;
      d   = ($urandom % 2) ? days_of(mon, y) : 1 + $urandom % days_of(mon, y);
      load($urandom % 2, $urandom % 2, $urandom % 2, s, m, h, w, d, mon, y);
      tick("R2 random", 0);
      tick("R3 random", it % 8 == 0);
    end

    finish_run();
  end
endmodule